// File: doc/BRIEF.md
# Ordered Active-Alarm List

This block keeps the alarms that are currently raised in a controller status area as a compact list, oldest first. Raising an alarm number appends it behind the entries already listed. Clearing a specific number takes that entry out, and every newer entry moves one place toward the front, so no gap is left. A separate command retires the oldest entry.

The list has sixteen slots, and each alarm number is 16 bits wide. The value 0 marks an empty slot, so 0 is never stored as an alarm. All slots are visible at once on a flat output bus. The block also presents the number of listed alarms and the alarm at the front of the list as outputs of their own. Every command completes in a single clock cycle, and the ready output stays high from the first cycle after reset.

Top module: `alarm_order_list`

## Requirements
- R1: A synchronous active-low reset clears every slot, the count and the head output to 0. The ready output reads 0 during reset and 1 from the first clock edge after reset is released.
- R2: A set command with a non-zero number that is not yet listed, on a list holding fewer than 16 entries, writes that number into slot index equal to the old count and increments the count.
- R3: When 16 entries are listed, a set command leaves all slots and the count unchanged.
- R4: A set command with number 0, or with a number already in the list, changes nothing.
- R5: A clear command whose number is listed removes that entry. Every later entry moves one slot toward slot 0, the last previously used slot becomes 0, and the count decrements.
- R6: A clear command whose number is not listed changes nothing.
- R7: A drop-oldest command on a non-empty list discards slot 0, moves every entry one slot toward slot 0 and decrements the count. On an empty list it changes nothing.
- R8: The head output always equals slot 0. With no alarm listed, the head, the count and all slots read 0.
- R9: When several command strobes are high in the same cycle, only one command acts. Clear has the highest priority, then drop-oldest, then set.
- R10: Each command's effect is visible on the outputs after exactly one clock edge, and ready stays high while commands are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_req | input | 1 | Append alarm_num to the tail of the list |
| clr_req | input | 1 | Remove alarm_num from the list |
| pop_req | input | 1 | Retire the oldest entry |
| alarm_num | input | 16 | Alarm number for set and clear commands |
| ready | output | 1 | High when commands are accepted |
| slots_flat | output | 256 | Slot i occupies bits [16*i+15 : 16*i]; slot 0 is the oldest |
| count | output | 5 | Number of listed alarms, 0 to 16 |
| head | output | 16 | Oldest listed alarm number, or 0 when the list is empty |

## Verification
The bench targets the following corner cases, and each one would expose a specific fault:
- Clearing the head entry, a middle entry and the tail entry. A faulty compaction would either leave a stale copy in the last used slot or shift entries that sit in front of the match.
- A set on a full list. A faulty design would overwrite slot 15 or let the count wrap.
- Sets with a zero or duplicate number, and a clear of an absent number. Each of these must leave the list untouched; a faulty design would grow or shrink the list.
- All three strobes raised together, and drop-oldest raised together with set. A faulty design would act on two commands in one cycle or apply the wrong command.

// File: rtl/alq_pkg.sv
// Package alq_pkg
// Shared types for the ordered alarm list: the command chosen each cycle.
// Assumes a single command is applied per clock cycle.
package alq_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SET  = 2'd1,
        OP_POP  = 2'd2,
        OP_CLR  = 2'd3
    } alq_op_e;

endpackage

// File: rtl/alq_match.sv
// Module alq_match
// Compares a key with every slot. Reports whether the key is listed, and
// builds a mask with a bit set at the matching slot and at every slot after it.
// Assumes the list holds no duplicates and that empty slots hold 0.
// A zero key never matches.
module alq_match #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic [DEPTH-1:0][W-1:0] slots,
    input  logic [W-1:0]            key,
    output logic                    hit,
    output logic [DEPTH-1:0]        at_or_after
);

    logic [DEPTH-1:0] eq;

    // Per-slot equality test and prefix OR that forms the shift mask.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g]          = (key != '0) && (slots[g] == key);
        assign at_or_after[g] = |eq[g:0];
    end

    // Key is present anywhere in the list.
    assign hit = |eq;

endmodule

// File: rtl/alq_decide.sv
// Module alq_decide
// Picks the one command that acts this cycle, using the priority
// clear > drop-oldest > set. A command that would have no effect is
// reduced to OP_NONE.
// Assumes count never exceeds DEPTH.
module alq_decide
    import alq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          set_req,
    input  logic          clr_req,
    input  logic          pop_req,
    input  logic [W-1:0]  num,
    input  logic          hit,
    input  logic [CW-1:0] cnt,
    output alq_op_e       op
);

    // Priority selection with qualification of each command.
    always_comb begin
        op = OP_NONE;
        if (clr_req) begin
            if (hit) op = OP_CLR;
        end else if (pop_req) begin
            if (cnt != '0) op = OP_POP;
        end else if (set_req) begin
            if ((num != '0) && !hit && (cnt < CW'(DEPTH))) op = OP_SET;
        end
    end

endmodule

// File: rtl/alarm_order_list.sv
// Module alarm_order_list
// Chronological list of active alarm numbers, with slot 0 the oldest.
// Set appends at the tail. Clear removes the matching entry and compacts
// the list. Drop-oldest retires slot 0. Outputs are all slots, the count
// and the head.
// Assumes: 0 marks an empty slot; one command acts per cycle;
// synchronous active-low reset.
module alarm_order_list
    import alq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_req,
    input  logic             clr_req,
    input  logic             pop_req,
    input  logic [W-1:0]     alarm_num,
    output logic             ready,
    output logic [DEPTH*W-1:0] slots_flat,
    output logic [CW-1:0]    count,
    output logic [W-1:0]     head
);

    logic [DEPTH-1:0][W-1:0] slot_q;
    logic [DEPTH-1:0][W-1:0] slot_d;
    logic [CW-1:0]           cnt_q;
    logic [CW-1:0]           cnt_d;
    logic                    ready_q;
    logic                    hit;
    logic [DEPTH-1:0]        shift_mask;
    alq_op_e                 op;

    alq_match #(.DEPTH(DEPTH), .W(W)) u_match (
        .slots       (slot_q),
        .key         (alarm_num),
        .hit         (hit),
        .at_or_after (shift_mask)
    );

    alq_decide #(.DEPTH(DEPTH), .W(W)) u_decide (
        .set_req (set_req),
        .clr_req (clr_req),
        .pop_req (pop_req),
        .num     (alarm_num),
        .hit     (hit),
        .cnt     (cnt_q),
        .op      (op)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [W-1:0] upper;
        logic [W-1:0] nxt;

        // Value arriving from the next newer slot; the last slot takes 0.
        if (g == DEPTH - 1) begin : g_last
            assign upper = '0;
        end else begin : g_mid
            assign upper = slot_q[g+1];
        end

        // Next value of this slot for the selected command.
        always_comb begin
            unique case (op)
                OP_CLR:  nxt = shift_mask[g] ? upper : slot_q[g];
                OP_POP:  nxt = upper;
                OP_SET:  nxt = (cnt_q == CW'(g)) ? alarm_num : slot_q[g];
                default: nxt = slot_q[g];
            endcase
        end

        assign slot_d[g] = nxt;
    end

    // Next count for the selected command.
    always_comb begin
        unique case (op)
            OP_SET:         cnt_d = cnt_q + 1'b1;
            OP_CLR, OP_POP: cnt_d = cnt_q - 1'b1;
            default:        cnt_d = cnt_q;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '0;
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            slot_q  <= slot_d;
            cnt_q   <= cnt_d;
            ready_q <= 1'b1;
        end
    end

    assign slots_flat = slot_q;
    assign count      = cnt_q;
    assign head       = slot_q[0];
    assign ready      = ready_q;

endmodule

// File: rtl/alarm_order_list_chk.sv
// Module alarm_order_list_chk
// Property checker for alarm_order_list, watching only its ports.
// Attached to the top module through the bind statement at the end of
// this file.
module alarm_order_list_chk #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               set_req,
    input logic               clr_req,
    input logic               pop_req,
    input logic [W-1:0]       alarm_num,
    input logic               ready,
    input logic [DEPTH*W-1:0] slots_flat,
    input logic [CW-1:0]      count,
    input logic [W-1:0]       head
);

    // The count never grows beyond the number of slots.
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // An empty list shows zeros on the head and on every slot.
    assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (head == '0) && (slots_flat == '0));

    // A set on a full list is discarded.
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !clr_req && !pop_req && count == CW'(DEPTH))
        |=> $stable(slots_flat) && (count == CW'(DEPTH)));

    // Drop-oldest on an empty list leaves it empty.
    assert_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !clr_req && count == '0) |=> (count == '0));

    // Drop-oldest promotes slot 1 to the head and shrinks the count by one.
    assert_pop_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !clr_req && count != '0)
        |=> (count == $past(count) - 1'b1) && (head == $past(slots_flat[2*W-1:W])));

    // A clear never grows the list.
    assert_clr_shrink_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (count <= $past(count)));

    // Clear takes priority: set is never acted on in the same cycle.
    assert_clr_over_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && set_req) |=> (count <= $past(count)));

    // Ready is high from the first edge after reset is released.
    assert_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ready);

endmodule

bind alarm_order_list alarm_order_list_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_req    (set_req),
    .clr_req    (clr_req),
    .pop_req    (pop_req),
    .alarm_num  (alarm_num),
    .ready      (ready),
    .slots_flat (slots_flat),
    .count      (count),
    .head       (head)
);

// File: tb/alarm_order_list_test.sv
`timescale 1ns/1ps
// Bench for alarm_order_list: a vector table walked by one loop, then
// directed tests for reset, the full list, compaction, priority and the
// empty list.
module alarm_order_list_test;

    localparam int DEPTH = 16;
    localparam int W     = 16;
    localparam int NV    = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              set_req = 1'b0;
    logic              clr_req = 1'b0;
    logic              pop_req = 1'b0;
    logic [W-1:0]      alarm_num = '0;
    logic              ready;
    logic [DEPTH*W-1:0] slots_flat;
    logic [4:0]        count;
    logic [W-1:0]      head;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alarm_order_list uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_req    (set_req),
        .clr_req    (clr_req),
        .pop_req    (pop_req),
        .alarm_num  (alarm_num),
        .ready      (ready),
        .slots_flat (slots_flat),
        .count      (count),
        .head       (head)
    );

    // Each entry: {op[2]=clear, op[1]=drop-oldest, op[0]=set, num,
    //              expected count, expected head, expected slot1, expected slot2}
    localparam logic [71:0] VEC [NV] = '{
        {3'b001, 16'd50,   5'd1, 16'd50, 16'd0,  16'd0 },
        {3'b001, 16'd25,   5'd2, 16'd50, 16'd25, 16'd0 },
        {3'b001, 16'd99,   5'd3, 16'd50, 16'd25, 16'd99},
        {3'b100, 16'd25,   5'd2, 16'd50, 16'd99, 16'd0 },
        {3'b001, 16'd15,   5'd3, 16'd50, 16'd99, 16'd15},
        {3'b001, 16'd70,   5'd4, 16'd50, 16'd99, 16'd15},
        {3'b001, 16'd65,   5'd5, 16'd50, 16'd99, 16'd15},
        {3'b001, 16'd38,   5'd6, 16'd50, 16'd99, 16'd15},
        {3'b001, 16'd110,  5'd7, 16'd50, 16'd99, 16'd15},
        {3'b001, 16'd151,  5'd8, 16'd50, 16'd99, 16'd15},
        {3'b001, 16'd210,  5'd9, 16'd50, 16'd99, 16'd15},
        {3'b010, 16'd0,    5'd8, 16'd99, 16'd15, 16'd70},
        {3'b001, 16'd0,    5'd8, 16'd99, 16'd15, 16'd70},  // R4 zero number ignored
        {3'b001, 16'd70,   5'd8, 16'd99, 16'd15, 16'd70},  // R4 duplicate ignored
        {3'b100, 16'd1234, 5'd8, 16'd99, 16'd15, 16'd70},  // R6 absent clear ignored
        {3'b100, 16'd99,   5'd7, 16'd15, 16'd70, 16'd65}   // R5 clear of the head
    };

    function automatic logic [W-1:0] slot(input int i);
        return slots_flat[i*W +: W];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Apply one command for one cycle; outputs are settled at the following negedge.
    task automatic cmd(input logic s, input logic c, input logic p, input logic [W-1:0] n);
        @(negedge clk);
        set_req = s; clr_req = c; pop_req = p; alarm_num = n;
        @(negedge clk);
        set_req = 1'b0; clr_req = 1'b0; pop_req = 1'b0; alarm_num = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "count in reset", count, 0);
        chk("R1", "head in reset", head, 0);
        chk("R1", "ready in reset", ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", ready, 1);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = VEC[v][71] ? "R5" : (VEC[v][70] ? "R7" : "R2");
            cmd(VEC[v][69], VEC[v][71], VEC[v][70], VEC[v][68:53]);
            chk(tag,  $sformatf("vec %0d count", v), count, VEC[v][52:48]);
            chk("R8", $sformatf("vec %0d head", v), head, VEC[v][47:32]);
            chk(tag,  $sformatf("vec %0d slot1", v), slot(1), VEC[v][31:16]);
            chk(tag,  $sformatf("vec %0d slot2", v), slot(2), VEC[v][15:0]);
        end
        // The list is now 15,70,65,38,110,151,210.

        for (int k = 1; k <= 9; k++) cmd(1'b1, 1'b0, 1'b0, W'(1000 + k));
        chk("R2", "count when full", count, 16);
        chk("R2", "slot15 when full", slot(15), 1009);

        cmd(1'b1, 1'b0, 1'b0, 16'd2000);
        chk("R3", "count after set on full", count, 16);
        chk("R3", "slot15 after set on full", slot(15), 1009);

        cmd(1'b0, 1'b1, 1'b0, 16'd38);     // middle entry, slot 3
        chk("R5", "count after middle clear", count, 15);
        chk("R5", "slot3 after middle clear", slot(3), 110);
        chk("R5", "slot14 after middle clear", slot(14), 1009);
        chk("R5", "slot15 after middle clear", slot(15), 0);

        cmd(1'b1, 1'b1, 1'b1, 16'd15);     // all strobes: only the clear acts
        chk("R9", "count with all strobes", count, 14);
        chk("R9", "head with all strobes", head, 70);
        chk("R9", "slot13 with all strobes", slot(13), 1009);

        @(negedge clk);
        set_req = 1'b1; pop_req = 1'b1; alarm_num = 16'd3000;   // drop-oldest beats set
        @(negedge clk);
        set_req = 1'b0; pop_req = 1'b0; alarm_num = '0;
        chk("R9", "count with drop and set", count, 13);
        chk("R9", "head with drop and set", head, 65);
        chk("R9", "slot13 with drop and set", slot(13), 0);
        chk("R10", "ready during commands", ready, 1);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "count after reset", count, 0);
        chk("R1", "slots after reset", (slots_flat == '0), 1);
        chk("R1", "ready held low in reset", ready, 0);
        rst_n = 1'b1;
        @(negedge clk);

        cmd(1'b0, 1'b0, 1'b1, 16'd0);
        chk("R7", "count after drop on empty", count, 0);
        chk("R7", "slots after drop on empty", (slots_flat == '0), 1);

        cmd(1'b1, 1'b0, 1'b0, 16'd7);
        chk("R10", "head one edge after set", head, 7);
        cmd(1'b0, 1'b1, 1'b0, 16'd7);
        chk("R8", "head when emptied", head, 0);
        chk("R8", "count when emptied", count, 0);
        chk("R8", "slots when emptied", (slots_flat == '0), 1);

        cmd(1'b1, 1'b0, 1'b0, 16'd5);
        cmd(1'b1, 1'b0, 1'b0, 16'd6);
        cmd(1'b0, 1'b1, 1'b0, 16'd6);      // tail entry
        chk("R5", "count after tail clear", count, 1);
        chk("R5", "slot1 after tail clear", slot(1), 0);
        chk("R5", "head after tail clear", head, 5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule